// File: doc/BRIEF.md
# Signal Peak Level Tracker

This block measures the level of a received baseband signal that arrives as signed samples, one per bit, each marked by a bit strobe. It holds two registers. One follows the positive excursions of the signal and the other follows the negative excursions. Once per bit it registers the midpoint of the two as the slicing threshold for bit decisions. Bias is the value zero.

Two controls pick how the registers move. A DC-acquire input, when it rises, starts a short clamp. The clamp lasts a set number of bit strobes and loads both registers with half the current sample. While DC-acquire stays high after the clamp, the registers capture new peaks quickly. When DC-acquire is low, an active-low hold input selects between two behaviours. With hold high, the registers average slowly and accurately toward the samples on their own side of the threshold. With hold low, charging stops and the registers leak toward zero with a very long time constant, so the threshold stays usable through a fade.

Top module: `lvl_tracker`

## Requirements
- R1: While reset is low, and in the first cycle after reset, the positive peak, the negative peak and the threshold all read 0.
- R2: On a bit strobe in clamp mode, both peak registers are loaded with the sample arithmetically shifted right by one. This is the midpoint between the sample and a bias of 0.
- R3: Clamp mode starts in the clock cycle in which DC-acquire is seen rising; a strobe in that same cycle counts as a clamp strobe. Clamp covers CLAMP_BITS bit strobes (default 1), and a fall of DC-acquire cancels the rest of it.
- R4: Fast mode is DC-acquire high outside clamp. On a strobe, if the sample exceeds the positive peak, the positive peak adds (sample − peak) >>> 1. If the sample is below the negative peak, the negative peak adds (sample − peak) >>> 1. A register that does not meet its condition keeps its value.
- R5: Averaging mode is DC-acquire low with hold high. Let mid = (pos + neg) >>> 1, taken from the values before the strobe. If the sample is at or above mid, the positive peak adds (sample − pos) >>> 5. Otherwise the negative peak adds (sample − neg) >>> 5.
- R6: Hold mode is DC-acquire low with hold low. On each strobe, each peak p becomes p − (p >>> 11).
- R7: While DC-acquire is high, the hold input has no effect: the peaks follow R2/R4.
- R8: In a cycle without a bit strobe, no output changes.
- R9: On each strobe, the threshold register loads (pos + neg) >>> 1, computed from the peak values held before that strobe's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_i | input | W | Signed filtered sample, two's complement |
| bit_stb_i | input | 1 | One-cycle strobe: sample_i is valid for this bit |
| dc_acq_i | input | 1 | DC-acquire control; a rise starts the clamp |
| hold_n_i | input | 1 | Active-low hold, used only while DC-acquire is low |
| pos_pk_o | output | W | Positive peak level, signed |
| neg_pk_o | output | W | Negative peak level, signed |
| thresh_o | output | W | Registered slicing threshold, signed |

## Verification
The bench drives a DC-acquire rise in the same cycle as a strobe. A design that starts the clamp one cycle late would run fast detection on that strobe and leave the two peaks unequal. It also raises DC-acquire with no strobe and drops it again before any strobe arrives. A design that latches the clamp request without cancelling it would load both peaks on the next averaging strobe. Hold low is driven together with DC-acquire high; a design with the wrong priority would decay the peaks instead of capturing the peak. The bench also drives full-scale negative samples and long hold runs, which expose a wrong shift, such as a logical in place of an arithmetic one, or the wrong widening of the difference. Those faults show up as sign flips or as a decay that moves away from zero.

// File: rtl/lvl_pkg.sv
package lvl_pkg;
   typedef enum logic [1:0] {
      M_HOLD  = 2'd0,
      M_AVG   = 2'd1,
      M_FAST  = 2'd2,
      M_CLAMP = 2'd3
   } lvl_mode_e;
endpackage

// File: rtl/lvl_mode_ctrl.sv
module lvl_mode_ctrl
   import lvl_pkg::*;
#(
   parameter int CLAMP_BITS = 1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      acq_i,
   input  logic      hold_n_i,
   input  logic      stb_i,
   output lvl_mode_e mode_o
);
   localparam int CW = $clog2(CLAMP_BITS + 1);

   if (CLAMP_BITS < 1) begin : g_bad_clamp
      $error("lvl_mode_ctrl: CLAMP_BITS must be at least 1");
   end

   logic          acq_q;
   logic [CW-1:0] cnt_q;
   logic          rise;

   assign rise = acq_i & ~acq_q;

   always_comb begin
      if (acq_i) mode_o = (rise || cnt_q != '0) ? M_CLAMP : M_FAST;
      else       mode_o = hold_n_i ? M_AVG : M_HOLD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acq_q <= 1'b0;
         cnt_q <= '0;
      end else begin
         acq_q <= acq_i;
         if (!acq_i)
            cnt_q <= '0;
         else if (rise)
            cnt_q <= stb_i ? CW'(CLAMP_BITS - 1) : CW'(CLAMP_BITS);
         else if (stb_i && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
      end
   end

   // R7: acquire dominates the hold control
   p_acq_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      acq_i |-> (mode_o == M_CLAMP || mode_o == M_FAST));

   // R3: the last clamp strobe ends clamp unless a new rise arrives
   p_clamp_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == M_CLAMP && stb_i && !rise && cnt_q == CW'(1))
      |=> (mode_o != M_CLAMP || (acq_i && !acq_q)));
endmodule

// File: rtl/lvl_peak_det.sv
module lvl_peak_det
   import lvl_pkg::*;
#(
   parameter int W       = 16,
   parameter bit IS_POS  = 1'b1,
   parameter int FAST_SH = 1,
   parameter int AVG_SH  = 5,
   parameter int HOLD_SH = 11
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                stb_i,
   input  lvl_mode_e           mode_i,
   input  logic signed [W-1:0] sample_i,
   input  logic signed [W-1:0] mid_i,
   output logic signed [W-1:0] pk_o
);
   localparam int XW = W + 1;

   if (FAST_SH < 1 || AVG_SH <= FAST_SH || HOLD_SH < 1) begin : g_bad_shift
      $error("lvl_peak_det: need 1 <= FAST_SH < AVG_SH and HOLD_SH >= 1");
   end

   logic signed [W-1:0]  pk_q, pk_nxt;
   logic signed [XW-1:0] diff, fast_x, avg_x;
   logic signed [W-1:0]  hold_v, clamp_v;
   logic                 capture, my_side;

   assign diff    = XW'(sample_i) - XW'(pk_q);
   assign fast_x  = XW'(pk_q) + (diff >>> FAST_SH);
   assign avg_x   = XW'(pk_q) + (diff >>> AVG_SH);
   assign hold_v  = pk_q - (pk_q >>> HOLD_SH);
   assign clamp_v = sample_i >>> 1;

   if (IS_POS) begin : g_pos
      assign capture = sample_i > pk_q;
      assign my_side = sample_i >= mid_i;
   end else begin : g_neg
      assign capture = sample_i < pk_q;
      assign my_side = sample_i < mid_i;
   end

   always_comb begin
      pk_nxt = pk_q;
      unique case (mode_i)
         M_CLAMP: pk_nxt = clamp_v;
         M_FAST:  if (capture) pk_nxt = W'(fast_x);
         M_AVG:   if (my_side) pk_nxt = W'(avg_x);
         M_HOLD:  pk_nxt = hold_v;
         default: pk_nxt = pk_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pk_q <= '0;
      else if (stb_i) pk_q <= pk_nxt;
   end

   assign pk_o = pk_q;

   function automatic logic [W:0] mag(input logic signed [W-1:0] v);
      logic signed [W:0] e;
      e = XW'(v);
      return (e < 0) ? -e : e;
   endfunction

   // R8: no strobe, no movement
   p_idle_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !stb_i |=> $stable(pk_o));

   // R6: hold never grows the magnitude
   p_hold_shrink_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_i && mode_i == M_HOLD) |=> mag(pk_o) <= mag($past(pk_o)));

   // R4: fast mode only pushes the peak outward
   if (IS_POS) begin : g_mono_pos
      p_fast_mono_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (stb_i && mode_i == M_FAST) |=> pk_o >= $past(pk_o));
   end else begin : g_mono_neg
      p_fast_mono_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (stb_i && mode_i == M_FAST) |=> pk_o <= $past(pk_o));
   end
endmodule

// File: rtl/lvl_tracker.sv
module lvl_tracker
   import lvl_pkg::*;
#(
   parameter int W          = 16,
   parameter int CLAMP_BITS = 1,
   parameter int FAST_SH    = 1,
   parameter int AVG_SH     = 5,
   parameter int HOLD_SH    = 11
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic signed [W-1:0] sample_i,
   input  logic                bit_stb_i,
   input  logic                dc_acq_i,
   input  logic                hold_n_i,
   output logic signed [W-1:0] pos_pk_o,
   output logic signed [W-1:0] neg_pk_o,
   output logic signed [W-1:0] thresh_o
);
   localparam int XW = W + 1;

   if (W < 4) begin : g_bad_width
      $error("lvl_tracker: W must be at least 4");
   end

   lvl_mode_e           mode;
   logic signed [W-1:0] pk [2];
   logic signed [XW-1:0] sum;
   logic signed [W-1:0] mid, thr_q;

   lvl_mode_ctrl #(.CLAMP_BITS(CLAMP_BITS)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .acq_i    (dc_acq_i),
      .hold_n_i (hold_n_i),
      .stb_i    (bit_stb_i),
      .mode_o   (mode)
   );

   assign sum = XW'(pk[0]) + XW'(pk[1]);
   assign mid = W'(sum >>> 1);

   for (genvar i = 0; i < 2; i++) begin : g_det
      lvl_peak_det #(
         .W       (W),
         .IS_POS  (i == 0),
         .FAST_SH (FAST_SH),
         .AVG_SH  (AVG_SH),
         .HOLD_SH (HOLD_SH)
      ) u_det (
         .clk      (clk),
         .rst_n    (rst_n),
         .stb_i    (bit_stb_i),
         .mode_i   (mode),
         .sample_i (sample_i),
         .mid_i    (mid),
         .pk_o     (pk[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         thr_q <= '0;
      else if (bit_stb_i) thr_q <= mid;
   end

   assign pos_pk_o = pk[0];
   assign neg_pk_o = pk[1];
   assign thresh_o = thr_q;

   // R2: a clamp strobe leaves both peaks equal
   p_clamp_equal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_stb_i && mode == M_CLAMP) |=> pos_pk_o == neg_pk_o);

   // R5: averaging moves at most one of the two peaks per strobe
   p_avg_one_side_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_stb_i && mode == M_AVG)
      |=> (pos_pk_o == $past(pos_pk_o) || neg_pk_o == $past(neg_pk_o)));

   // R9: the threshold only moves on a strobe
   p_thr_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_stb_i |=> $stable(thresh_o));
endmodule

// File: tb/tb_lvl_tracker.sv
module tb_lvl_tracker;
   localparam int W = 16;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic signed [W-1:0] sample_i = '0;
   logic                bit_stb_i = 1'b0;
   logic                dc_acq_i = 1'b0;
   logic                hold_n_i = 1'b1;
   logic signed [W-1:0] pos_pk_o, neg_pk_o, thresh_o;

   always #10 clk = ~clk;

   lvl_tracker #(.W(W)) dut (
      .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .bit_stb_i(bit_stb_i),
      .dc_acq_i(dc_acq_i), .hold_n_i(hold_n_i),
      .pos_pk_o(pos_pk_o), .neg_pk_o(neg_pk_o), .thresh_o(thresh_o)
   );

   int m_pos = 0, m_neg = 0, m_thr = 0, m_cnt = 0;
   bit m_acq_q = 1'b0;
   int n_chk = 0, n_err = 0;

   task automatic chk(string tag, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic int f_mid(int a, int b);
      return (a + b) >>> 1;
   endfunction

   task automatic check_all(string tag);
      chk(tag, "pos_pk", int'(pos_pk_o), m_pos);
      chk(tag, "neg_pk", int'(neg_pk_o), m_neg);
      chk("R9", "thresh", int'(thresh_o), m_thr);
   endtask

   // called at a falling edge; drives for one rising edge, then checks
   task automatic step(int x, bit stb, bit acq, bit hn, string tag);
      bit    rise, clamp;
      string t;
      int    md;
      sample_i = W'(x); bit_stb_i = stb; dc_acq_i = acq; hold_n_i = hn;
      rise  = acq && !m_acq_q;
      clamp = acq && (rise || m_cnt != 0);
      if (!stb)       t = "R8";
      else if (clamp) t = "R2";
      else if (acq)   t = hn ? "R4" : "R7";
      else            t = hn ? "R5" : "R6";
      if (tag != "") t = tag;
      if (stb) begin
         md    = f_mid(m_pos, m_neg);
         m_thr = md;
         if (clamp) begin
            m_pos = x >>> 1; m_neg = x >>> 1;
         end else if (acq) begin
            if (x > m_pos) m_pos = m_pos + ((x - m_pos) >>> 1);
            if (x < m_neg) m_neg = m_neg + ((x - m_neg) >>> 1);
         end else if (hn) begin
            if (x >= md) m_pos = m_pos + ((x - m_pos) >>> 5);
            else         m_neg = m_neg + ((x - m_neg) >>> 5);
         end else begin
            m_pos = m_pos - (m_pos >>> 11);
            m_neg = m_neg - (m_neg >>> 11);
         end
      end
      if (!acq)      m_cnt = 0;
      else if (rise) m_cnt = stb ? 0 : 1;
      else if (stb && m_cnt != 0) m_cnt = m_cnt - 1;
      m_acq_q = acq;
      @(posedge clk);
      @(negedge clk);
      check_all(t);
   endtask

   function automatic int rnd_sample();
      return int'($urandom_range(65535)) - 32768;
   endfunction

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog run did not finish actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin : stim
      bit acq, hn;
      void'($urandom(32'd589));
      repeat (3) @(negedge clk);
      check_all("R1");
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1");

      // clamp with the rise in the same cycle as a strobe
      step(1000, 1, 1, 1, "R2");
      step(1500, 1, 1, 1, "R3");        // clamp over after one strobe
      step(-1000, 1, 1, 0, "R7");       // hold low ignored under acquire
      step(20000, 0, 1, 1, "R8");
      step(20000, 1, 1, 1, "R4");
      step(100, 1, 1, 1, "R4");         // inside both peaks: no move
      // rise without strobe, then clamp on the next strobe
      step(0, 0, 0, 1, "");
      step(0, 0, 1, 1, "R3");
      step(-6000, 1, 1, 1, "R3");
      step(7000, 1, 1, 1, "R3");
      // clamp cancelled by a fall before any strobe
      step(0, 0, 0, 1, "");
      step(0, 0, 1, 1, "");
      step(0, 0, 0, 1, "R3");
      step(8000, 1, 0, 1, "R3");
      // full-scale negative clamp
      step(0, 0, 0, 1, "");
      step(-32768, 1, 1, 1, "R2");
      // pump to large peaks, then hold
      for (int i = 0; i < 12; i++) step(32767, 1, 1, 1, "R4");
      for (int i = 0; i < 12; i++) step(-32768, 1, 1, 1, "R4");
      for (int i = 0; i < 40; i++) step(rnd_sample(), (i % 3) != 0, 0, 0, "");
      step(0, 1, 0, 0, "R6");
      // averaging from a settled state
      for (int i = 0; i < 300; i++) step(rnd_sample(), 1'b1, 0, 1, "");
      // constrained random mix
      acq = 1'b0; hn = 1'b1;
      for (int i = 0; i < 3000; i++) begin
         if ($urandom_range(19) == 0) acq = ~acq;
         if ($urandom_range(9) == 0)  hn  = ~hn;
         step(rnd_sample(), $urandom_range(1) == 1, acq, hn, "");
      end
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule